// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps through a 128-word control store, one address per clock. It holds the control address register (CAR), which points at the microinstruction being fetched. Each cycle it picks the next address from one of four sources: the current address plus one, the address field of the microinstruction, a single subroutine return register (SBR), or an address built from the machine instruction's opcode. Only CAR leaves the block. The control store, the datapath and the decoding of the microoperation fields sit outside it.

Two small fields of the fetched microinstruction steer the choice. A 2-bit test selector picks one status bit: always-true, the instruction's indirect bit, the accumulator sign, or the accumulator-is-zero flag. A 2-bit branch kind names the action: jump, call, return or opcode map. Jump and call are conditional on the selected bit. A call also saves the return point. The map action sends each opcode to its own group of four words in the lower half of the store.

Top module: `mseq_next_addr`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, CAR becomes 64, the first word of the fetch routine, and SBR becomes 0. A return straight after reset therefore gives CAR = 0.
- R2: The test selector picks the tested bit T: 00 gives 1, 01 gives `ind_bit`, 10 gives `acc_sign`, 11 gives `acc_zero`.
- R3: With branch kind 00 (jump), CAR takes `branch_addr` when T = 1 and CAR+1 when T = 0.
- R4: With branch kind 01 (call) and T = 1, CAR takes `branch_addr` and, at the same edge, SBR takes the old CAR+1.
- R5: With branch kind 01 and T = 0, CAR takes CAR+1 and SBR keeps its value.
- R6: With branch kind 10 (return), CAR takes SBR whatever the value of T.
- R7: With branch kind 11 (map), CAR takes {0, opcode[3:0], 00}, that is opcode×4, whatever the value of T.
- R8: The increment wraps from 127 to 0. This covers the value saved by a call made from address 127.
- R9: SBR holds one address only. A second call before a return overwrites it, and repeated returns all go to the latest saved address.
- R10: Jump, return and map never change SBR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; CAR and SBR update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cond_sel | input | 2 | Test selector of the current microinstruction |
| branch_kind | input | 2 | Branch kind of the current microinstruction |
| branch_addr | input | 7 | Address field of the current microinstruction |
| ind_bit | input | 1 | Indirect bit of the current machine instruction |
| opcode | input | 4 | Opcode of the current machine instruction |
| acc_sign | input | 1 | Accumulator sign bit |
| acc_zero | input | 1 | High when the accumulator is zero |
| car | output | 7 | Control address register |

## Verification
The bound checker checks these on every cycle:
- the reset value;
- unconditional jumps and calls;
- a jump that falls through on a clear sign bit;
- the map and return targets;
- that SBR stays put under jump, return and map.

The bench's scenarios cover the rest:
- every pairing of branch kind, test selector and tested-bit value, compared against a behavioural model;
- wrap-around at 127;
- an untaken call followed by a return;
- nested calls overwriting the single return register.

Some of these effects show at the CAR port only through a later return, so a scenario is the only way to observe them.

// File: rtl/mseq_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the microprogram next-address sequencer.
// Assumes 2-bit branch-kind, test-select and source-select codes.
package mseq_pkg;
    typedef enum logic [1:0] {
        BK_JUMP = 2'b00,
        BK_CALL = 2'b01,
        BK_RET  = 2'b10,
        BK_MAP  = 2'b11
    } branch_kind_e;

    typedef enum logic [1:0] {
        CS_ALWAYS   = 2'b00,
        CS_INDIRECT = 2'b01,
        CS_SIGN     = 2'b10,
        CS_ZERO     = 2'b11
    } cond_sel_e;

    typedef enum logic [1:0] {
        SRC_INC    = 2'b00,
        SRC_BRANCH = 2'b01,
        SRC_RETURN = 2'b10,
        SRC_MAP    = 2'b11
    } src_sel_e;
endpackage

// File: rtl/mseq_cond_mux.sv
`timescale 1ns/1ps
// Module: mseq_cond_mux
// Picks the one status bit that the current microinstruction tests.
// Assumes a 2-bit selector and four status inputs, the first tied to 1.
module mseq_cond_mux
    import mseq_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       ind_bit,
    input  logic       acc_sign,
    input  logic       acc_zero,
    output logic       test_bit
);
    // Four-input multiplexer over the status sources.
    always_comb begin
        case (cond_sel_e'(cond_sel))
            CS_ALWAYS:   test_bit = 1'b1;
            CS_INDIRECT: test_bit = ind_bit;
            CS_SIGN:     test_bit = acc_sign;
            default:     test_bit = acc_zero;
        endcase
    end
endmodule

// File: rtl/mseq_select_logic.sv
`timescale 1ns/1ps
// Module: mseq_select_logic
// Turns the branch kind and the tested bit into the address-source select
// and the return-register load enable, using closed-form equations.
// Assumes the encodings in mseq_pkg.
module mseq_select_logic
    import mseq_pkg::*;
(
    input  logic [1:0] branch_kind,
    input  logic       test_bit,
    output src_sel_e   src_sel,
    output logic       sbr_load
);
    logic sel_hi;
    logic sel_lo;

    // Source select: upper bit follows the kind, lower bit mixes in the test.
    always_comb begin
        sel_hi   = branch_kind[1];
        sel_lo   = (~branch_kind[1] & test_bit) | (branch_kind[1] & branch_kind[0]);
        src_sel  = src_sel_e'({sel_hi, sel_lo});
        sbr_load = ~branch_kind[1] & branch_kind[0] & test_bit;
    end
endmodule

// File: rtl/mseq_addr_mux.sv
`timescale 1ns/1ps
// Module: mseq_addr_mux
// Four-way source multiplexer for the next control address, including
// the opcode mapping {0, opcode, zeros}.
// Assumes ADDR_W = 1 + OP_W + (number of zero LSBs), with at least one zero LSB.
module mseq_addr_mux
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int OP_W   = 4
) (
    input  src_sel_e          src_sel,
    input  logic [ADDR_W-1:0] car_inc,
    input  logic [ADDR_W-1:0] branch_addr,
    input  logic [ADDR_W-1:0] sbr,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] next_addr
);
    localparam int PAD_W = ADDR_W - 1 - OP_W;

    logic [ADDR_W-1:0] mapped;

    // Opcode mapping: MSB cleared, opcode in the middle, PAD_W zero LSBs.
    always_comb mapped = {1'b0, opcode, {PAD_W{1'b0}}};

    // Route the selected source to the next address.
    always_comb begin
        case (src_sel)
            SRC_INC:    next_addr = car_inc;
            SRC_BRANCH: next_addr = branch_addr;
            SRC_RETURN: next_addr = sbr;
            default:    next_addr = mapped;
        endcase
    end
endmodule

// File: rtl/mseq_next_addr.sv
`timescale 1ns/1ps
// Module: mseq_next_addr (top)
// Holds the control address register and the single subroutine return
// register, and advances CAR once per clock from one of four sources.
// Assumes the microinstruction fields are stable before each rising edge,
// and a synchronous active-low reset.
module mseq_next_addr
    import mseq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int RESET_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cond_sel,
    input  logic [1:0]        branch_kind,
    input  logic [ADDR_W-1:0] branch_addr,
    input  logic              ind_bit,
    input  logic [OP_W-1:0]   opcode,
    input  logic              acc_sign,
    input  logic              acc_zero,
    output logic [ADDR_W-1:0] car
);
    localparam logic [ADDR_W-1:0] RST_CAR = ADDR_W'(RESET_ADDR);
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);

    logic [ADDR_W-1:0] car_q;
    logic [ADDR_W-1:0] sbr_q;
    logic [ADDR_W-1:0] car_inc;
    logic [ADDR_W-1:0] next_addr;
    logic              test_bit;
    logic              sbr_load;
    src_sel_e          src_sel;

    // Incrementer; it wraps naturally at the top of the store.
    always_comb car_inc = car_q + ONE;

    mseq_cond_mux u_cond (
        .cond_sel (cond_sel),
        .ind_bit  (ind_bit),
        .acc_sign (acc_sign),
        .acc_zero (acc_zero),
        .test_bit (test_bit)
    );

    mseq_select_logic u_sel (
        .branch_kind (branch_kind),
        .test_bit    (test_bit),
        .src_sel     (src_sel),
        .sbr_load    (sbr_load)
    );

    mseq_addr_mux #(
        .ADDR_W (ADDR_W),
        .OP_W   (OP_W)
    ) u_mux (
        .src_sel     (src_sel),
        .car_inc     (car_inc),
        .branch_addr (branch_addr),
        .sbr         (sbr_q),
        .opcode      (opcode),
        .next_addr   (next_addr)
    );

    // Control address register: reset to the fetch entry, else advance.
    always_ff @(posedge clk) begin
        if (!rst_n) car_q <= RST_CAR;
        else        car_q <= next_addr;
    end

    // Return register: cleared on reset, loaded with CAR+1 on a taken call.
    always_ff @(posedge clk) begin
        if (!rst_n)        sbr_q <= '0;
        else if (sbr_load) sbr_q <= car_inc;
    end

    assign car = car_q;
endmodule

// File: rtl/mseq_checker.sv
`timescale 1ns/1ps
// Module: mseq_checker
// Property checks for mseq_next_addr, attached with bind below.
// Assumes the encodings in mseq_pkg; observes the return register directly.
module mseq_checker
    import mseq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int OP_W       = 4,
    parameter int RESET_ADDR = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cond_sel,
    input logic [1:0]        branch_kind,
    input logic [ADDR_W-1:0] branch_addr,
    input logic [OP_W-1:0]   opcode,
    input logic              acc_sign,
    input logic [ADDR_W-1:0] car,
    input logic [ADDR_W-1:0] sbr
);
    localparam int PAD_W = ADDR_W - 1 - OP_W;
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] RST_CAR = ADDR_W'(RESET_ADDR);

    // R1: the first cycle out of reset starts at the fetch entry.
    assert_reset_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> car == RST_CAR);

    // R3: an unconditional jump lands on the address field.
    assert_jump_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_kind == BK_JUMP && cond_sel == CS_ALWAYS) |=> car == $past(branch_addr));

    // R3: a jump testing a clear sign bit falls through.
    assert_jump_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_kind == BK_JUMP && cond_sel == CS_SIGN && !acc_sign) |=> car == $past(car) + ONE);

    // R4: an unconditional call saves the return point and branches.
    assert_call_save_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (branch_kind == BK_CALL && cond_sel == CS_ALWAYS)
            |=> (sbr == $past(car) + ONE) && (car == $past(branch_addr)));

    // R6: a return goes to the saved address.
    assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        branch_kind == BK_RET |=> car == $past(sbr));

    // R7: map forms {0, opcode, zeros}.
    assert_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        branch_kind == BK_MAP |=> car == {1'b0, $past(opcode), {PAD_W{1'b0}}});

    // R10: jump, return and map leave the return register alone.
    assert_sbr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        branch_kind != BK_CALL |=> $stable(sbr));
endmodule

bind mseq_next_addr mseq_checker #(
    .ADDR_W     (ADDR_W),
    .OP_W       (OP_W),
    .RESET_ADDR (RESET_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cond_sel    (cond_sel),
    .branch_kind (branch_kind),
    .branch_addr (branch_addr),
    .opcode      (opcode),
    .acc_sign    (acc_sign),
    .car         (car),
    .sbr         (sbr_q)
);

// File: tb/sim_mseq_next_addr.sv
`timescale 1ns/1ps
// Bench: behavioural reference model of CAR/SBR, compared after every clock.
module sim_mseq_next_addr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cond_sel = 2'd0;
    logic [1:0] branch_kind = 2'd0;
    logic [6:0] branch_addr = 7'd0;
    logic       ind_bit = 1'b0;
    logic [3:0] opcode = 4'd0;
    logic       acc_sign = 1'b0;
    logic       acc_zero = 1'b0;
    logic [6:0] car;

    integer checks = 0;
    integer fails = 0;
    integer car_m = 64;
    integer sbr_m = 0;
    integer cycles = 0;

    always #5 clk = ~clk;

    mseq_next_addr u0 (
        .clk (clk), .rst_n (rst_n), .cond_sel (cond_sel),
        .branch_kind (branch_kind), .branch_addr (branch_addr),
        .ind_bit (ind_bit), .opcode (opcode), .acc_sign (acc_sign),
        .acc_zero (acc_zero), .car (car)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check_car(input string tag);
        checks = checks + 1;
        if (integer'(car) !== car_m) begin
            fails = fails + 1;
            $display("FAIL %s car=%0d expected=%0d", tag, car, car_m);
        end
    endtask

    // Apply one microinstruction (called at a falling edge), advance the
    // model at the rising edge, check CAR at the next falling edge.
    task automatic step(input int bk, input int cd, input int ad, input bit ind,
                        input int op, input bit sgn, input bit zr, input string tag);
        int t;
        branch_kind = 2'(bk); cond_sel = 2'(cd); branch_addr = 7'(ad);
        ind_bit = ind; opcode = 4'(op); acc_sign = sgn; acc_zero = zr;
        @(posedge clk);
        case (cd)
            0: t = 1;
            1: t = ind;
            2: t = sgn;
            default: t = zr;
        endcase
        case (bk)
            0: car_m = t ? ad : (car_m + 1) % 128;
            1: if (t != 0) begin sbr_m = (car_m + 1) % 128; car_m = ad; end
               else car_m = (car_m + 1) % 128;
            2: car_m = sbr_m;
            default: car_m = op * 4;
        endcase
        @(negedge clk);
        check_car(tag);
    endtask

    initial begin
        // R1: reset state.
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        car_m = 64; sbr_m = 0;
        check_car("R1 reset CAR");
        step(2, 0, 5, 0, 0, 0, 0, "R1 R6 return after reset");

        // R2..R7: every branch kind, test selector and tested-bit value.
        for (int bk = 0; bk < 4; bk++) begin
            for (int cd = 0; cd < 4; cd++) begin
                for (int tv = 0; tv < 2; tv++) begin
                    bit ind, sgn, zr;
                    ind = (cd == 1) ? tv[0] : ~tv[0];
                    sgn = (cd == 2) ? tv[0] : ~tv[0];
                    zr  = (cd == 3) ? tv[0] : ~tv[0];
                    case (bk)
                        0: step(bk, cd, (bk*29 + cd*13 + tv*7 + 5) % 128, ind,
                                (cd*3 + tv) % 16, sgn, zr, "R3 R2 jump");
                        1: step(bk, cd, (bk*29 + cd*13 + tv*7 + 5) % 128, ind,
                                (cd*3 + tv) % 16, sgn, zr, tv ? "R4 R2 call" : "R5 R2 call");
                        2: step(bk, cd, (bk*29 + cd*13 + tv*7 + 5) % 128, ind,
                                (cd*3 + tv) % 16, sgn, zr, "R6 return");
                        default: step(bk, cd, (bk*29 + cd*13 + tv*7 + 5) % 128, ind,
                                (cd*5 + tv*3 + 1) % 16, sgn, zr, "R7 map");
                    endcase
                end
            end
        end

        // R5: untaken call, then return shows SBR unchanged.
        step(1, 0, 30, 0, 0, 0, 0, "R4 call to 30");
        step(1, 3, 90, 0, 0, 0, 0, "R5 untaken call");
        step(2, 0, 0, 0, 0, 0, 0, "R5 return after untaken call");

        // R7: map corners, opcode 0 and 15.
        step(3, 1, 99, 1, 0, 1, 1, "R7 map opcode 0");
        step(3, 2, 99, 0, 15, 0, 0, "R7 map opcode 15");

        // R8: wrap 127 -> 0 on increment and on a saved return point.
        step(0, 0, 127, 0, 0, 0, 0, "R3 jump to 127");
        step(0, 2, 50, 0, 0, 0, 0, "R8 wrap increment");
        step(0, 0, 127, 0, 0, 0, 0, "R3 jump to 127");
        step(1, 1, 20, 1, 0, 0, 0, "R8 call from 127");
        step(2, 0, 0, 0, 0, 0, 0, "R8 return wraps to 0");

        // R9: nested calls overwrite the single return register.
        step(0, 0, 10, 0, 0, 0, 0, "R3 jump to 10");
        step(1, 0, 70, 0, 0, 0, 0, "R9 outer call");
        step(1, 2, 90, 0, 0, 1, 0, "R9 inner call");
        step(2, 0, 0, 0, 0, 0, 0, "R9 first return");
        step(2, 0, 0, 0, 0, 0, 0, "R9 second return");

        // R10: jump, map and return leave SBR; a later return shows it.
        step(0, 0, 40, 0, 0, 0, 0, "R10 jump");
        step(3, 0, 0, 0, 9, 0, 0, "R10 map");
        step(2, 3, 0, 0, 0, 0, 1, "R10 return");
        step(2, 0, 0, 0, 0, 0, 0, "R10 return again");

        // R1: reset in mid-run restores entry and clears SBR.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        car_m = 64; sbr_m = 0;
        check_car("R1 mid-run reset");
        step(2, 0, 0, 0, 0, 0, 0, "R1 SBR cleared");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule